// File: doc/BRIEF.md
# USB High-Speed Chirp Negotiator

This block sits on the device side of a USB 2.0 port and decides, during a bus reset, whether the link runs at full speed (12 Mbit/s) or high speed (480 Mbit/s). It takes the decoded line state and a free-running time-base strobe. It drives four outputs: the full-speed D+ pull-up enable, a request to drive a device K chirp, the high-speed termination enable and a speed flag. All durations are counted in strobes, so a bench can shrink a reset of several milliseconds to a few dozen cycles.

After attach the device presents itself as full speed. The upstream port starts a reset by holding SE0. Once SE0 has lasted a qualifying time, the block requests a K chirp for a fixed time and then releases it. It then listens for the upstream port's alternating K and J chirps. A chirp counts only once it has stayed stable for a minimum time, and only a K followed by a J completes a pair. When enough complete pairs arrive inside the listening window, the pull-up drops and the high-speed terminations and speed flag rise in the same cycle. If the window closes first, the device stays at full speed.

States and transitions:
- `ST_FS_IDLE` goes to `ST_RST_QUAL` when SE0 is seen.
- `ST_RST_QUAL` returns to `ST_FS_IDLE` if the line leaves SE0. It goes to `ST_DEV_CHIRP` once SE0 has lasted `RST_MIN_TICKS`.
- `ST_DEV_CHIRP` goes to `ST_HOST_WAIT` after `CHIRP_K_TICKS`.
- `ST_HOST_WAIT` goes to `ST_HS_RUN` when the pair target is met. That check wins over the window. Otherwise it goes to `ST_FS_RUN` after `HOST_WINDOW_TICKS`.
- `ST_FS_RUN` returns to `ST_FS_IDLE` when the line leaves SE0.
- `ST_HS_RUN` is left only by `rst_n`.

Top module: `hs_chirp_ctrl`

## Requirements
- R1: After `rst_n` is released, `fs_pullup_en` is 1 and `chirp_k_drv`, `hs_term_en` and `hs_mode` are 0. Line state is encoded as 2'b00 SE0, 2'b01 J, 2'b10 K and 2'b11 SE1.
- R2: An SE0 that ends before `RST_MIN_TICKS` strobes (default 8) is ignored. No chirp is requested, and a later SE0 restarts the qualification from zero.
- R3: An SE0 held for `RST_MIN_TICKS` strobes raises `chirp_k_drv`, with the pull-up still enabled. The request is held for `CHIRP_K_TICKS` strobes (default 20) and then released.
- R4: In the listening phase, a K or J counts only after it has been stable for `CHIRP_STABLE_TICKS` strobes (default 4). Shorter chirps are not counted.
- R5: A pair is completed only by an accepted J that directly follows an accepted K. A repeated K or J, even with SE0 between the repeats, does not add a pair.
- R6: SE1 seen while listening clears the pair count and the last accepted chirp at once.
- R7: When `PAIRS_REQ` pairs (default 3) are complete, `fs_pullup_en` falls in the same cycle that `hs_term_en` and `hs_mode` rise. If the last pair completes in the cycle the window expires, high speed wins.
- R8: If the pairs are not complete within `HOST_WINDOW_TICKS` strobes (default 120) of the chirp release, the block stays at full speed with the pull-up on. Once the line leaves SE0, a new reset can start a new negotiation.
- R9: While `tick` is 0, no duration advances.
- R10: Once in high speed, the outputs hold whatever the line does, until `rst_n`.
- R11: `fs_pullup_en` and `hs_term_en` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base strobe; every duration counts these |
| line_st | input | 2 | Decoded line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| fs_pullup_en | output | 1 | Enables the full-speed D+ pull-up |
| chirp_k_drv | output | 1 | Requests the transceiver to drive a K chirp |
| hs_term_en | output | 1 | Enables the high-speed terminations |
| hs_mode | output | 1 | 1 once high speed has been negotiated |

## Verification
Two functions can fall in the same cycle: completion of the last chirp pair and expiry of the listening window. The bench places the start of the final J so that its pair becomes complete exactly as the window count is reached. It then repeats the run with that J one strobe later. The first run must end in high speed and the second at full speed with the pull-up kept on. A second coincidence, SE1 arriving right after two good pairs, is judged by showing that one further pair is then not enough.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_e;

    typedef enum logic [2:0] {
        ST_FS_IDLE   = 3'd0,
        ST_RST_QUAL  = 3'd1,
        ST_DEV_CHIRP = 3'd2,
        ST_HOST_WAIT = 3'd3,
        ST_HS_RUN    = 3'd4,
        ST_FS_RUN    = 3'd5
    } neg_state_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_K    = 2'd1,
        ACC_J    = 2'd2
    } acc_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/chirp_tick_timer.sv
// Saturating strobe counter; expired once the count reaches the limit.
module chirp_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expired
);
    localparam logic [W-1:0] CNT_TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != CNT_TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= limit);

endmodule

// File: rtl/chirp_pair_counter.sv
// Filters host chirps for stability and counts complete K-then-J pairs.
module chirp_pair_counter
    import chirp_pkg::*;
#(
    parameter int STABLE_TICKS = 4,
    parameter int PAIRS_REQ    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic [1:0] line_st,
    output logic       pairs_done
);
    localparam int SW = $clog2(STABLE_TICKS + 1);
    localparam int PW = $clog2(PAIRS_REQ + 1);
    localparam logic [PW-1:0] PAIR_TGT = PW'(PAIRS_REQ);

    logic [1:0]    cur_q;
    logic          stab_clr;
    logic          stab_ok;
    logic          qual;
    acc_e          acc_q;
    logic [PW-1:0] pairs_q;

    // Stability window restarts on any change of the sampled line
    assign stab_clr = !en || (line_st != cur_q);

    chirp_tick_timer #(.W(SW)) u_stab (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (stab_clr),
        .tick    (tick),
        .limit   (SW'(STABLE_TICKS)),
        .expired (stab_ok)
    );

    assign qual = en && stab_ok && (line_st == cur_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= LS_SE0;
        end else begin
            cur_q <= line_st;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= ACC_NONE;
            pairs_q <= '0;
        end else if (!en || (line_st == LS_SE1)) begin
            acc_q   <= ACC_NONE;
            pairs_q <= '0;
        end else if (qual) begin
            if (cur_q == LS_K) begin
                acc_q <= ACC_K;
            end else if (cur_q == LS_J) begin
                if ((acc_q == ACC_K) && (pairs_q != PAIR_TGT)) begin
                    pairs_q <= pairs_q + 1'b1;
                end
                acc_q <= ACC_J;
            end
        end
    end

    assign pairs_done = (pairs_q >= PAIR_TGT);

endmodule

// File: rtl/chirp_neg_fsm.sv
// Negotiation sequencer: state register, next-state logic, Moore outputs.
module chirp_neg_fsm
    import chirp_pkg::*;
#(
    parameter int TMR_W             = 8,
    parameter int RST_MIN_TICKS     = 8,
    parameter int CHIRP_K_TICKS     = 20,
    parameter int HOST_WINDOW_TICKS = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       line_st,
    input  logic             tmr_expired,
    input  logic             pairs_done,
    output logic             tmr_clr,
    output logic [TMR_W-1:0] tmr_limit,
    output logic             listen_en,
    output logic             fs_pullup_en,
    output logic             chirp_k_drv,
    output logic             hs_term_en,
    output logic             hs_mode
);
    neg_state_e state_q;
    neg_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FS_IDLE: begin
                if (line_st == LS_SE0) state_d = ST_RST_QUAL;
            end
            ST_RST_QUAL: begin
                if (line_st != LS_SE0) state_d = ST_FS_IDLE;
                else if (tmr_expired)  state_d = ST_DEV_CHIRP;
            end
            ST_DEV_CHIRP: begin
                if (tmr_expired) state_d = ST_HOST_WAIT;
            end
            ST_HOST_WAIT: begin
                if (pairs_done)       state_d = ST_HS_RUN;
                else if (tmr_expired) state_d = ST_FS_RUN;
            end
            ST_FS_RUN: begin
                if (line_st != LS_SE0) state_d = ST_FS_IDLE;
            end
            ST_HS_RUN: begin
                state_d = ST_HS_RUN;
            end
            default: state_d = ST_FS_IDLE;
        endcase
    end

    assign tmr_clr = (state_d != state_q);

    always_comb begin
        fs_pullup_en = 1'b1;
        chirp_k_drv  = 1'b0;
        hs_term_en   = 1'b0;
        hs_mode      = 1'b0;
        listen_en    = 1'b0;
        tmr_limit    = '0;
        unique case (state_q)
            ST_FS_IDLE:   ;
            ST_RST_QUAL:  tmr_limit = TMR_W'(RST_MIN_TICKS);
            ST_DEV_CHIRP: begin
                chirp_k_drv = 1'b1;
                tmr_limit   = TMR_W'(CHIRP_K_TICKS);
            end
            ST_HOST_WAIT: begin
                listen_en = 1'b1;
                tmr_limit = TMR_W'(HOST_WINDOW_TICKS);
            end
            ST_FS_RUN:    ;
            ST_HS_RUN: begin
                fs_pullup_en = 1'b0;
                hs_term_en   = 1'b1;
                hs_mode      = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/hs_chirp_ctrl.sv
module hs_chirp_ctrl
    import chirp_pkg::*;
#(
    parameter int RST_MIN_TICKS      = 8,
    parameter int CHIRP_K_TICKS      = 20,
    parameter int CHIRP_STABLE_TICKS = 4,
    parameter int HOST_WINDOW_TICKS  = 120,
    parameter int PAIRS_REQ          = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] line_st,
    output logic       fs_pullup_en,
    output logic       chirp_k_drv,
    output logic       hs_term_en,
    output logic       hs_mode
);
    localparam int LIM_MAX = max_of(max_of(RST_MIN_TICKS, CHIRP_K_TICKS), HOST_WINDOW_TICKS);
    localparam int TMR_W   = $clog2(LIM_MAX + 1);

    logic             tmr_clr;
    logic             tmr_expired;
    logic [TMR_W-1:0] tmr_limit;
    logic             listen_en;
    logic             pairs_done;

    chirp_tick_timer #(.W(TMR_W)) u_phase_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .tick    (tick),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    chirp_pair_counter #(
        .STABLE_TICKS (CHIRP_STABLE_TICKS),
        .PAIRS_REQ    (PAIRS_REQ)
    ) u_pairs (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (listen_en),
        .tick       (tick),
        .line_st    (line_st),
        .pairs_done (pairs_done)
    );

    chirp_neg_fsm #(
        .TMR_W             (TMR_W),
        .RST_MIN_TICKS     (RST_MIN_TICKS),
        .CHIRP_K_TICKS     (CHIRP_K_TICKS),
        .HOST_WINDOW_TICKS (HOST_WINDOW_TICKS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_st      (line_st),
        .tmr_expired  (tmr_expired),
        .pairs_done   (pairs_done),
        .tmr_clr      (tmr_clr),
        .tmr_limit    (tmr_limit),
        .listen_en    (listen_en),
        .fs_pullup_en (fs_pullup_en),
        .chirp_k_drv  (chirp_k_drv),
        .hs_term_en   (hs_term_en),
        .hs_mode      (hs_mode)
    );

endmodule

// File: rtl/chirp_neg_checker.sv
module chirp_neg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] line_st,
    input logic       fs_pullup_en,
    input logic       chirp_k_drv,
    input logic       hs_term_en,
    input logic       hs_mode
);
    AST_PULLUP_TERM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        fs_pullup_en |-> !hs_term_en); // R11

    AST_HS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hs_mode |=> hs_mode); // R10

    AST_CHIRP_FS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_k_drv |-> (fs_pullup_en && !hs_mode)); // R3

    AST_CHIRP_AFTER_SE0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chirp_k_drv) |-> ($past(line_st) == 2'b00)); // R3

    AST_HS_NOT_FROM_CHIRP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> (!$past(chirp_k_drv) && $past(fs_pullup_en))); // R7

    AST_HS_SWITCH_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> (hs_term_en && !fs_pullup_en)); // R7

endmodule

bind hs_chirp_ctrl chirp_neg_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_st      (line_st),
    .fs_pullup_en (fs_pullup_en),
    .chirp_k_drv  (chirp_k_drv),
    .hs_term_en   (hs_term_en),
    .hs_mode      (hs_mode)
);

// File: tb/tb_hs_chirp_ctrl.sv
`timescale 1ns/1ps
module tb_hs_chirp_ctrl;

    localparam logic [1:0] SE0 = 2'b00;
    localparam logic [1:0] LJ  = 2'b01;
    localparam logic [1:0] LK  = 2'b10;
    localparam logic [1:0] SE1 = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [1:0] line_st = 2'b01;
    logic       fs_pullup_en, chirp_k_drv, hs_term_en, hs_mode;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hs_chirp_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .line_st      (line_st),
        .fs_pullup_en (fs_pullup_en),
        .chirp_k_drv  (chirp_k_drv),
        .hs_term_en   (hs_term_en),
        .hs_mode      (hs_mode)
    );

    // {line[13:12], hold cycles[11:4], expected {pullup,chirp,term,hs}[3:0]}
    localparam int NV = 14;
    localparam logic [13:0] VEC [NV] = '{
        {2'b01, 8'd5,  4'b1000},
        {2'b00, 8'd5,  4'b1000},
        {2'b01, 8'd3,  4'b1000},
        {2'b00, 8'd12, 4'b1100},
        {2'b00, 8'd10, 4'b1100},
        {2'b00, 8'd12, 4'b1000},
        {2'b10, 8'd7,  4'b1000},
        {2'b01, 8'd7,  4'b1000},
        {2'b10, 8'd7,  4'b1000},
        {2'b01, 8'd7,  4'b1000},
        {2'b10, 8'd7,  4'b1000},
        {2'b01, 8'd9,  4'b0011},
        {2'b00, 8'd20, 4'b0011},
        {2'b10, 8'd10, 4'b0011}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:       return "R1";
            1, 2:    return "R2";
            3, 4, 5: return "R3";
            11:      return "R7 R11";
            12, 13:  return "R10";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [3:0] obs();
        return {fs_pullup_en, chirp_k_drv, hs_term_en, hs_mode};
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {pullup,chirp,term,hs} actual %b expected %b", tag, act, exp);
        end
    endtask

    // Called at a negedge: drive, wait n rising edges, return at the next negedge
    task automatic hold(input logic [1:0] ls, input int n);
        line_st = ls;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        tick    = 1'b1;
        line_st = LJ;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pair(input int kn, input int jn);
        hold(LK, kn);
        hold(LJ, jn);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 reset", obs(), 4'b1000);

        // Table walk: reset, glitch, device chirp, three pairs, high speed held
        for (int i = 0; i < NV; i++) begin
            hold(VEC[i][13:12], int'(VEC[i][11:4]));
            chk(vec_tag(i), obs(), VEC[i][3:0]);
        end

        // R1: reset out of high speed
        do_reset();
        chk("R1 reset from HS", obs(), 4'b1000);

        // R4: short chirps do not count
        hold(LJ, 2);
        hold(SE0, 40);
        for (int i = 0; i < 5; i++) pair(3, 3);
        pair(7, 7);
        pair(7, 9);
        chk("R4 short chirps ignored", obs(), 4'b1000);
        pair(7, 9);
        chk("R4 third stable pair", obs(), 4'b0011);

        // R5: repeats do not add pairs
        do_reset();
        hold(LJ, 2);
        hold(SE0, 40);
        pair(7, 7);
        hold(SE0, 7);
        hold(LJ, 7);
        hold(LK, 7);
        hold(SE0, 7);
        hold(LK, 7);
        hold(LJ, 9);
        chk("R5 repeated J/K", obs(), 4'b1000);
        pair(7, 9);
        chk("R5 completing pair", obs(), 4'b0011);

        // R6: SE1 restarts counting
        do_reset();
        hold(LJ, 2);
        hold(SE0, 40);
        pair(7, 7);
        pair(7, 7);
        hold(SE1, 2);
        pair(7, 9);
        chk("R6 SE1 cleared count", obs(), 4'b1000);
        pair(7, 7);
        pair(7, 9);
        chk("R6 recount after SE1", obs(), 4'b0011);

        // R7: last pair completes in the cycle the window expires -> HS wins
        do_reset();
        hold(LJ, 2);
        hold(SE0, 110);
        pair(7, 7);
        pair(7, 7);
        pair(7, 10);
        chk("R7 pair at window edge", obs(), 4'b0011);

        // R8: one strobe later the window wins
        do_reset();
        hold(LJ, 2);
        hold(SE0, 111);
        pair(7, 7);
        pair(7, 7);
        pair(7, 10);
        chk("R8 window edge fallback", obs(), 4'b1000);

        // R8: no host chirps at all, then re-arm
        do_reset();
        hold(LJ, 2);
        hold(SE0, 200);
        chk("R8 no host chirps", obs(), 4'b1000);
        pair(7, 9);
        chk("R8 late pair ignored", obs(), 4'b1000);
        hold(SE0, 12);
        chk("R8 re-armed reset", obs(), 4'b1100);

        // R9: tick low freezes qualification
        do_reset();
        hold(LJ, 2);
        tick = 1'b0;
        hold(SE0, 30);
        chk("R9 tick low", obs(), 4'b1000);
        tick = 1'b1;
        hold(SE0, 12);
        chk("R9 tick resumed", obs(), 4'b1100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule